// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block is the multicycle control engine behind a block load or block store instruction. It is handed a 16-bit register-select mask, the value and number of a base register, and five control bits. It then steps through the selected registers one at a time and performs one 32-bit memory access for each. The five control bits are:

- load or store;
- upward or downward addressing;
- offset applied before or after each access;
- address writeback;
- full-word load of the program counter register.

Memory is reached through a request/acknowledge port that may insert any number of wait states. The register file sits outside the block. It is read through an index and data pair, and written through a strobe that carries a per-bit write enable.

Registers are always laid out in memory in ascending order, with the lowest-numbered register at the lowest address, whichever direction is chosen. The address moves by 4 bytes for each register. When writeback is requested, a final write puts the base address, moved by 4 bytes for each transferred register, back into the base register. Register 15 holds both the program counter and the status bits. When it is loaded with the full-load bit clear, only the program-counter field is written, so the load behaves as a jump.

Top module: `mtx_seq`

## Requirements
- R1: During and right after a reset cycle, `busy`, `done`, `mem_req` and `rf_we` are all low.
- R2: A transfer makes exactly one acknowledged memory access for each set mask bit, and visits the registers in ascending register number.
- R3: With `up_dir`=1 the first access is at `base_addr`+4 when `pre_idx`=1, or at `base_addr` when `pre_idx`=0. Each later access is 4 bytes higher.
- R4: With `up_dir`=0 and n set mask bits, the lowest register goes to the lowest address. That address is `base_addr`-4n when `pre_idx`=1, or `base_addr`-4n+4 when `pre_idx`=0, and the addresses ascend by 4.
- R5: A store (`is_load`=0) drives `mem_we`=1 and `mem_wdata` equal to the register file word at `rf_rd_idx`. A load (`is_load`=1) drives `mem_we`=0 and, in the acknowledging cycle, pulses `rf_we` with `rf_wr_data`=`mem_rdata` to that register.
- R6: A load of register 15 with `full_psr`=0 writes only the bits set in `PC_FIELD` (default 32'h03FF_FFFC), leaving the other bits of register 15 unchanged. With `full_psr`=1, and for every other register, `rf_wr_bits` is all ones.
- R7: With `wback`=1, one cycle after the last acknowledged access, `rf_we` writes `base_addr`+4n (upward) or `base_addr`-4n (downward) to `base_reg`, with all bits enabled. With `wback`=0 no such write happens.
- R8: An all-zero mask raises `done` on the cycle after `start`. It makes no memory request and no register write, including no writeback.
- R9: `busy` is high from the cycle after `start` until the final access and the optional writeback are complete. It is followed by a single-cycle `done` pulse. A `start` seen while busy is ignored.
- R10: While `mem_req` is high and not acknowledged, the request stays high and `mem_addr` and `mem_we` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; sampled only while idle |
| reg_mask | input | 16 | Register-select mask, bit i selects register i |
| base_addr | input | 32 | Current value of the base register |
| base_reg | input | 4 | Number of the base register (writeback target) |
| pre_idx | input | 1 | 1: step before each access, 0: step after |
| up_dir | input | 1 | 1: addresses above base, 0: below base |
| wback | input | 1 | Write the final address back to the base register |
| is_load | input | 1 | 1: memory to registers, 0: registers to memory |
| full_psr | input | 1 | Loading register 15 writes all bits when 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (store) when high |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| rf_wr_bits | output | 32 | Per-bit write enable for `rf_wr_data` |

## Verification
The hardest case to reach from the ports is a downward, post-indexed load. In this case the lowest address is not the base and must be derived from the popcount. The same case also needs wait states, so that the held-request rule is exercised and a second `start` can land in the middle of the busy window.

The bench drives that case with a memory responder that stretches every acknowledge by a chosen number of cycles. While the transfer is under way it pulses `start` again with a full mask, then confirms that the access count, the register writes and the writeback match the first command only.

Register 15 loads are run twice, with the full-load bit clear and then set, over a register value of all ones. This exposes which bits the partial write touched.

// File: rtl/mtx_pkg.sv
// Shared types for the multiple-register transfer sequencer.
// Assumes: no parameters; only the FSM encoding lives here.
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } mtx_state_t;
endpackage

// File: rtl/mtx_popcnt.sv
// Counts the set bits of a vector.
// Assumes: CW is wide enough to hold N.
module mtx_popcnt #(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Sum every bit of the vector into the count.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/mtx_pick.sv
// Finds the lowest set bit of a vector, as an index and as a one-hot vector.
// Assumes: idx is zero and onehot is all zero when the vector is empty.
module mtx_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan from the top so that the lowest set bit is the last one assigned.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Isolate the lowest set bit with the two's-complement trick.
    assign onehot = vec & (~vec + N'(1));
endmodule

// File: rtl/mtx_addr.sv
// Computes the first access address and the writeback address of a block
// transfer from the base address, the register count and the direction and
// indexing bits. The lowest register always maps to the lowest address.
// Assumes: STEP is a power of two (bytes per word).
module mtx_addr #(
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] first,
    output logic [AW-1:0] final_addr
);
    localparam int SH = $clog2(STEP);

    logic [AW-1:0] span;
    logic [AW-1:0] low;

    // Byte span covered by the whole transfer.
    assign span = {{(AW-CW){1'b0}}, count} << SH;

    // Lowest address of a downward block.
    assign low = base - span;

    // Choose the first access address and the writeback value.
    always_comb begin
        if (up) begin
            first      = pre ? base + AW'(STEP) : base;
            final_addr = base + span;
        end else begin
            first      = pre ? low : low + AW'(STEP);
            final_addr = low;
        end
    end
endmodule

// File: rtl/mtx_seq.sv
// Multiple-register transfer sequencer. On start it captures the command,
// then walks the mask from the lowest set bit upward, issuing one memory word
// access per register on a request/acknowledge port. Loads write the register
// file in the acknowledging cycle; stores read it combinationally. An optional
// writeback state returns the final address to the base register, and a
// one-cycle done state closes every command.
// Assumes: rf_rd_data follows rf_rd_idx within the same cycle; mem_rdata is
// valid whenever mem_ack is high; base_addr is word aligned.
module mtx_seq #(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          NREG     = 16,
    parameter logic [31:0] PC_FIELD = 32'h03FF_FFFC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NREG-1:0]         reg_mask,
    input  logic [AW-1:0]           base_addr,
    input  logic [$clog2(NREG)-1:0] base_reg,
    input  logic                    pre_idx,
    input  logic                    up_dir,
    input  logic                    wback,
    input  logic                    is_load,
    input  logic                    full_psr,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic                    mem_ack,
    input  logic [DW-1:0]           mem_rdata,
    output logic [$clog2(NREG)-1:0] rf_rd_idx,
    input  logic [DW-1:0]           rf_rd_data,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_wr_idx,
    output logic [DW-1:0]           rf_wr_data,
    output logic [DW-1:0]           rf_wr_bits
);
    import mtx_pkg::*;

    localparam int IW   = $clog2(NREG);
    localparam int CW   = $clog2(NREG + 1);
    localparam int STEP = DW / 8;

    mtx_state_t      state;
    logic [NREG-1:0] rem_mask;
    logic [AW-1:0]   cur_addr;
    logic [AW-1:0]   wb_addr;
    logic            lat_load;
    logic            lat_full;
    logic            lat_wb;
    logic [IW-1:0]   lat_breg;

    logic [CW-1:0]   sel_cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_addr;
    logic [IW-1:0]   pick_idx;
    logic [NREG-1:0] pick_oh;
    logic            last_one;
    logic            in_xfer;

    mtx_popcnt #(.N(NREG), .CW(CW)) u_cnt (
        .vec (reg_mask),
        .cnt (sel_cnt)
    );

    mtx_addr #(.AW(AW), .CW(CW), .STEP(STEP)) u_addr (
        .base       (base_addr),
        .count      (sel_cnt),
        .up         (up_dir),
        .pre        (pre_idx),
        .first      (first_addr),
        .final_addr (final_addr)
    );

    mtx_pick #(.N(NREG), .IW(IW)) u_pick (
        .vec    (rem_mask),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // Flag the final register of the walk.
    assign last_one = (rem_mask == pick_oh);
    assign in_xfer  = (state == ST_XFER);

    // Sequencer state, remaining mask, address pointer and captured command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rem_mask <= '0;
            cur_addr <= '0;
            wb_addr  <= '0;
            lat_load <= 1'b0;
            lat_full <= 1'b0;
            lat_wb   <= 1'b0;
            lat_breg <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rem_mask <= reg_mask;
                        cur_addr <= first_addr;
                        wb_addr  <= final_addr;
                        lat_load <= is_load;
                        lat_full <= full_psr;
                        lat_wb   <= wback;
                        lat_breg <= base_reg;
                        state    <= (reg_mask == '0) ? ST_DONE : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        rem_mask <= rem_mask & ~pick_oh;
                        cur_addr <= cur_addr + AW'(STEP);
                        if (last_one) begin
                            state <= lat_wb ? ST_WBACK : ST_DONE;
                        end
                    end
                end
                ST_WBACK: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Status outputs decoded from the state.
    assign busy = in_xfer || (state == ST_WBACK);
    assign done = (state == ST_DONE);

    // Memory port: one word per selected register.
    assign mem_req   = in_xfer;
    assign mem_we    = in_xfer && !lat_load;
    assign mem_addr  = cur_addr;
    assign mem_wdata = rf_rd_data;
    assign rf_rd_idx = pick_idx;

    // Register file write strobe for loaded words and for the writeback.
    always_comb begin
        rf_we      = 1'b0;
        rf_wr_idx  = pick_idx;
        rf_wr_data = mem_rdata;
        rf_wr_bits = '1;
        if (state == ST_WBACK) begin
            rf_we      = 1'b1;
            rf_wr_idx  = lat_breg;
            rf_wr_data = DW'(wb_addr);
        end else if (in_xfer && lat_load && mem_ack) begin
            rf_we = 1'b1;
            if (pick_idx == IW'(NREG - 1) && !lat_full) begin
                rf_wr_bits = DW'(PC_FIELD);
            end
        end
    end
endmodule

// File: rtl/mtx_seq_chk.sv
// Protocol checker for mtx_seq, attached to every instance by bind.
// Assumes: reset is synchronous and active low.
module mtx_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          rf_we,
    input logic [DW-1:0] rf_wr_bits
);
    // R1: a reset cycle leaves every strobe low on the next cycle.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req && !rf_we));

    // R2: memory requests only occur inside the busy window.
    assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: a register write during an access is a load completing.
    assert_load_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && mem_req) |-> (mem_ack && !mem_we));

    // R7: the writeback write enables every bit.
    assert_wb_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !mem_req) |-> (rf_wr_bits == '1));

    // R9: done lasts exactly one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy only ends by entering the done cycle.
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> done);

    // R10: an unacknowledged request holds its address and direction.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind mtx_seq mtx_seq_chk #(.AW(AW), .DW(DW)) u_mtx_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we),
    .rf_wr_bits (rf_wr_bits)
);

// File: tb/tb_mtx_seq.sv
// Directed bench for mtx_seq: models memory and the register file, one task per scenario.
module tb_mtx_seq;
    localparam logic [31:0] PC_BITS = 32'h03FF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_mask = '0;
    logic [31:0] base_addr = '0;
    logic [3:0]  base_reg = '0;
    logic        pre_idx = 1'b0, up_dir = 1'b0, wback = 1'b0, is_load = 1'b0, full_psr = 1'b0;
    logic        busy, done, mem_req, mem_we, rf_we;
    logic [31:0] mem_addr, mem_wdata, rf_wr_data, rf_wr_bits;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data;

    logic [31:0] mem [256];
    logic [31:0] regs [16];
    logic [31:0] snap [16];

    // Access and register-write logs of the current command.
    logic [31:0] a_addr [40];
    logic        a_we [40];
    logic [31:0] a_wdata [40];
    logic [3:0]  a_idx [40];
    int          nacc;
    logic [3:0]  w_idx [40];
    logic [31:0] w_data [40];
    logic [31:0] w_bits [40];
    logic        w_mem [40];
    int          nrw;

    int waits = 0;
    int wcnt = 0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int run_cycles;
    bit busy_gap;

    always #4 clk = ~clk;

    mtx_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
        .base_addr(base_addr), .base_reg(base_reg), .pre_idx(pre_idx),
        .up_dir(up_dir), .wback(wback), .is_load(is_load), .full_psr(full_psr),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_wr_bits(rf_wr_bits)
    );

    assign rf_rd_data = regs[rf_rd_idx];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Log completed accesses and apply register file writes at the clock edge.
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_req && mem_ack && nacc < 40) begin
                a_addr[nacc] = mem_addr; a_we[nacc] = mem_we;
                a_wdata[nacc] = mem_wdata; a_idx[nacc] = rf_rd_idx;
                nacc++;
            end
            if (rf_we && nrw < 40) begin
                w_idx[nrw] = rf_wr_idx; w_data[nrw] = rf_wr_data;
                w_bits[nrw] = rf_wr_bits; w_mem[nrw] = mem_req;
                nrw++;
                regs[rf_wr_idx] = (regs[rf_wr_idx] & ~rf_wr_bits) | (rf_wr_data & rf_wr_bits);
            end
        end
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Memory responder: acknowledge after 'waits' idle cycles.
    always @(negedge clk) begin
        if (!mem_req || mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt >= waits) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        end else begin
            wcnt++;
        end
    end

    task automatic init_state();
        for (int i = 0; i < 256; i++) mem[i] = {8'hC3, 8'(i), 8'(~i), 8'(i * 3)};
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0101;
    endtask

    // Issue one command and wait for done; optionally pulse start again mid-run.
    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] br,
                          input bit p, input bit u, input bit w, input bit l, input bit s,
                          input bit inject);
        @(negedge clk);
        for (int i = 0; i < 16; i++) snap[i] = regs[i];
        nacc = 0; nrw = 0; busy_gap = 0;
        reg_mask = m; base_addr = b; base_reg = br;
        pre_idx = p; up_dir = u; wback = w; is_load = l; full_psr = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_cycles = 1;
        while (!done && run_cycles < 500) begin
            if (!busy) busy_gap = 1;
            if (inject && run_cycles == 3) begin
                reg_mask = 16'hFFFF; is_load = 1'b0; base_addr = 32'h300;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            run_cycles++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R9", "done reached", 32'(done), 32'd1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done single cycle",
            {30'd0, busy, done}, 32'd0);
    endtask

    // Check accesses, register writes and writeback against the requirements.
    task automatic verify_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] br,
                             input bit p, input bit u, input bit w, input bit l, input bit s);
        int n;
        int k;
        logic [31:0] lowest;
        logic [31:0] wbv;
        logic [31:0] expv;
        n = $countones(m);
        if (u) lowest = p ? b + 32'd4 : b;
        else   lowest = p ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
        wbv = u ? b + 32'(4 * n) : b - 32'(4 * n);
        chk(nacc == n, "R2", "access count", 32'(nacc), 32'(n));
        chk(!busy_gap, "R9", "busy held", 32'(busy_gap), 32'd0);
        k = 0;
        for (int r = 0; r < 16; r++) begin
            if (m[r] && k < nacc) begin
                chk(a_addr[k] == lowest + 32'(4 * k), u ? "R3" : "R4", "address",
                    a_addr[k], lowest + 32'(4 * k));
                chk(a_we[k] == !l, "R5", "write enable", 32'(a_we[k]), 32'(!l));
                if (!l) begin
                    chk(a_idx[k] == 4'(r), "R2", "store order", 32'(a_idx[k]), 32'(r));
                    chk(a_wdata[k] == snap[r], "R5", "store data", a_wdata[k], snap[r]);
                end else if (k < nrw) begin
                    chk(w_idx[k] == 4'(r), "R2", "load order", 32'(w_idx[k]), 32'(r));
                    expv = a_addr[k] >> 2;
                    chk(w_data[k] == {8'hC3, 8'(expv), 8'(~expv), 8'(expv * 3)}, "R5",
                        "load data", w_data[k], {8'hC3, 8'(expv), 8'(~expv), 8'(expv * 3)});
                    expv = (r == 15 && !s) ? PC_BITS : 32'hFFFF_FFFF;
                    chk(w_bits[k] == expv, "R6", "write bits", w_bits[k], expv);
                end
                k++;
            end
        end
        expv = 32'((l ? n : 0) + ((w && n > 0) ? 1 : 0));
        chk(nrw == int'(expv), "R7", "register write count", 32'(nrw), expv);
        if (w && n > 0 && nrw > 0) begin
            chk(w_idx[nrw-1] == br && !w_mem[nrw-1], "R7", "writeback index",
                32'(w_idx[nrw-1]), 32'(br));
            chk(w_data[nrw-1] == wbv, "R7", "writeback value", w_data[nrw-1], wbv);
            chk(regs[br] == wbv, "R7", "base register", regs[br], wbv);
        end
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && mem_req == 0 && rf_we == 0, "R1", "reset outputs",
            {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    endtask

    task automatic t_store_up_pre();
        waits = 0;
        run_op(16'hA012, 32'h100, 4'd13, 1, 1, 1, 0, 0, 0);
        verify_op(16'hA012, 32'h100, 4'd13, 1, 1, 1, 0, 0);
        chk(mem[(32'h104 >> 2)] == snap[1], "R5", "memory word after store",
            mem[(32'h104 >> 2)], snap[1]);
    endtask

    task automatic t_store_down_pre_full();
        waits = 1;
        run_op(16'hFFFF, 32'h200, 4'd0, 1, 0, 0, 0, 0, 0);
        verify_op(16'hFFFF, 32'h200, 4'd0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_load_down_post_wait_inject();
        waits = 2;
        run_op(16'h00F0, 32'h180, 4'd2, 0, 0, 1, 1, 0, 1);
        // The injected start (full mask) must not add accesses.
        verify_op(16'h00F0, 32'h180, 4'd2, 0, 0, 1, 1, 0);
        chk(nacc == 4, "R9", "start ignored while busy", 32'(nacc), 32'd4);
    endtask

    task automatic t_load_r15_partial();
        logic [31:0] mv;
        waits = 0;
        regs[15] = 32'hFFFF_FFFF;
        mem[32'h44 >> 2] = 32'h1234_5678;
        mv = 32'h1234_5678;
        run_op(16'h8001, 32'h40, 4'd3, 0, 1, 0, 1, 0, 0);
        chk(regs[15] == ((32'hFFFF_FFFF & ~PC_BITS) | (mv & PC_BITS)), "R6", "r15 pc only",
            regs[15], (32'hFFFF_FFFF & ~PC_BITS) | (mv & PC_BITS));
        chk(regs[3] == snap[3], "R7", "no writeback when disabled", regs[3], snap[3]);
        chk(nacc == 2 && a_addr[0] == 32'h40, "R3", "post-index first address",
            a_addr[0], 32'h40);
    endtask

    task automatic t_load_r15_full();
        waits = 1;
        regs[15] = 32'hFFFF_FFFF;
        mem[32'h44 >> 2] = 32'h1234_5678;
        run_op(16'h8000, 32'h40, 4'd3, 1, 1, 0, 1, 1, 0);
        chk(regs[15] == 32'h1234_5678, "R6", "r15 full word", regs[15], 32'h1234_5678);
    endtask

    task automatic t_zero_mask();
        waits = 0;
        run_op(16'h0000, 32'h80, 4'd5, 1, 1, 1, 1, 1, 0);
        chk(run_cycles == 1, "R8", "done next cycle", 32'(run_cycles), 32'd1);
        chk(nacc == 0 && nrw == 0, "R8", "no access or write", 32'(nacc + nrw), 32'd0);
        chk(regs[5] == snap[5], "R8", "base untouched", regs[5], snap[5]);
    endtask

    task automatic t_up_post_wb_wait();
        waits = 3;
        run_op(16'h0C21, 32'h20, 4'd9, 0, 1, 1, 1, 0, 0);
        verify_op(16'h0C21, 32'h20, 4'd9, 0, 1, 1, 1, 0);
    endtask

    initial begin
        init_state();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_up_pre();
        t_store_down_pre_full();
        init_state();
        t_load_down_post_wait_inject();
        t_load_r15_partial();
        t_load_r15_full();
        t_zero_mask();
        t_up_post_wb_wait();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule